// File: doc/BRIEF.md
# Genlockable Video Sync Generator

This block derives the video timing signals from a pixel clock that is already phase-locked at 260 periods per horizontal line. A line rate near 15,750 Hz and a field rate near 60 Hz follow from it. It drives horizontal drive, vertical drive, blanking, composite sync and a colour burst flag. It also drives a one-cycle strobe at the start of each line and another at the start of each field, and a field-parity level. All outputs are active-high and registered.

Two counters set the position. One is a pixel counter over the line. The other is a half-line counter over the field. A field is 262.5 lines (525 half-lines), so the two interlaced fields start at pixel 0 and at pixel 130 in turn. Two small state machines follow these counters, and the outputs are decoded from their states.

The horizontal machine steps through `H_SYNC` (count reaches 0), `H_GAP` (count 20), `H_BURST` (count 24), `H_BACK` (count 34) and `H_ACTIVE` (count 45). Any state goes to `H_SYNC` when the count returns to 0. The vertical machine steps through `V_SYNC` (field start), `V_BLANK` (half-line 18) and `V_ACTIVE` (half-line 42). Any state goes to `V_SYNC` when a field begins.

When `lock_en` is high, the horizontal and vertical reference pulses from an external source force the counters back to their start, so the generator follows that source. When `lock_en` is low, the generator runs freely.

Top module: `video_sync_gen`

## Requirements
- R1: In free run, `line_start` pulses for one cycle exactly every 260 clocks.
- R2: `hdrive` is high for pixel positions 0 to 19 of every line and low elsewhere.
- R3: `blank` is high for pixel positions 0 to 44 of every line, and for the whole of the first 42 half-lines (21 lines) of each field.
- R4: `burst` is high for pixel positions 24 to 33, except during the vertical sync interval, when it stays low.
- R5: `vdrive` is high for the first 18 half-lines (9 lines) of each field. A field lasts 525 half-lines. Consecutive free-running fields start at pixel 0 and at pixel 130 in turn, and `field_odd` toggles at each natural field start.
- R6: `csync` equals `hdrive` outside the vertical sync interval and its inverse inside it (`hdrive` XOR `vdrive`).
- R7: If `ref_hsync` is high at a clock edge while `lock_en` is high, the outputs after that edge show pixel position 0 (`line_start` and `hdrive` high).
- R8: If `ref_vsync` is high at a clock edge while `lock_en` is high, the outputs after that edge show half-line 0 of a field with `field_odd` = 1 (`field_start` and `vdrive` high). The pixel position is not changed.
- R9: While `lock_en` is low, `ref_hsync` and `ref_vsync` have no effect on any output.
- R10: While `rst` is high, all outputs are low. After the first clock edge with `rst` low, the outputs show pixel 0 of half-line 0 with `field_odd` = 0.
- R11: `field_start` is high for exactly the one cycle in which a field begins, either at its natural end or at a genlock vertical pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, 260 periods per line |
| rst | input | 1 | Synchronous reset, active high |
| lock_en | input | 1 | Allows the reference pulses to reset the counters |
| ref_hsync | input | 1 | Horizontal reference pulse from the external source |
| ref_vsync | input | 1 | Vertical reference pulse from the external source |
| hdrive | output | 1 | Horizontal drive |
| vdrive | output | 1 | Vertical drive |
| blank | output | 1 | Combined horizontal and vertical blanking |
| csync | output | 1 | Composite sync |
| burst | output | 1 | Colour burst flag |
| line_start | output | 1 | Strobe on the first clock of each line |
| field_start | output | 1 | Strobe on the first clock of each field |
| field_odd | output | 1 | Field parity |

## Verification
Every output shows the position reached at a clock edge from the end of that edge onward. A reference pulse sampled at an edge is therefore visible in the sample taken half a period later. The bench's model advances its pixel, half-line and parity integers at the same rising edge as the design, using the same input values. It compares all eight outputs at the following falling edge, so each result is checked in the cycle it is due, and no comparison waits a cycle or compares a cycle early. The directed genlock and ignore checks drive a pulse on one falling edge and read the outputs on the next.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    typedef enum logic [2:0] {
        H_SYNC,
        H_GAP,
        H_BURST,
        H_BACK,
        H_ACTIVE
    } hphase_t;

    typedef enum logic [1:0] {
        V_SYNC,
        V_BLANK,
        V_ACTIVE
    } vphase_t;

endpackage

// File: rtl/sync_hcount.sv
module sync_hcount
    import sync_gen_pkg::*;
#(
    parameter int LINE_CLKS   = 260,
    parameter int HSYNC_W     = 20,
    parameter int BURST_START = 24,
    parameter int BURST_W     = 10,
    parameter int HBLANK_W    = 45
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    take_h,
    output hphase_t hph_nxt,
    output logic    line_begin,
    output logic    half_begin
);

    localparam int PW = $clog2(LINE_CLKS);
    localparam logic [PW-1:0] P_LAST   = PW'(LINE_CLKS - 1);
    localparam logic [PW-1:0] P_HALF   = PW'(LINE_CLKS / 2);
    localparam logic [PW-1:0] P_GAP    = PW'(HSYNC_W);
    localparam logic [PW-1:0] P_BURST  = PW'(BURST_START);
    localparam logic [PW-1:0] P_BACK   = PW'(BURST_START + BURST_W);
    localparam logic [PW-1:0] P_ACTIVE = PW'(HBLANK_W);

    logic [PW-1:0] pix;
    logic [PW-1:0] pix_nxt;
    hphase_t       hph;

    // next pixel position: genlock pulse or wrap sends it to 0
    always_comb begin
        if (take_h || pix == P_LAST) begin
            pix_nxt = '0;
        end else begin
            pix_nxt = pix + 1'b1;
        end
        line_begin = (pix_nxt == '0);
        half_begin = (pix_nxt == '0) || (pix_nxt == P_HALF);
    end

    // horizontal phase transitions, decided on the next count
    always_comb begin
        hph_nxt = hph;
        if (pix_nxt == '0) begin
            hph_nxt = H_SYNC;
        end else begin
            unique case (hph)
                H_SYNC:   if (pix_nxt == P_GAP)    hph_nxt = H_GAP;
                H_GAP:    if (pix_nxt == P_BURST)  hph_nxt = H_BURST;
                H_BURST:  if (pix_nxt == P_BACK)   hph_nxt = H_BACK;
                H_BACK:   if (pix_nxt == P_ACTIVE) hph_nxt = H_ACTIVE;
                H_ACTIVE: hph_nxt = H_ACTIVE;
            endcase
        end
    end

    // state register: reset parks at the last pixel so the first edge lands on 0
    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= P_LAST;
            hph <= H_ACTIVE;
        end else begin
            pix <= pix_nxt;
            hph <= hph_nxt;
        end
    end

    AST_PIX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!take_h && pix != P_LAST) |=> (pix == $past(pix) + 1'b1)); // R1
    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pix == P_LAST) |=> (pix == '0 && hph == H_SYNC)); // R1
    AST_GLOCK_H: assert property (@(posedge clk) disable iff (rst)
        take_h |=> (pix == '0 && hph == H_SYNC)); // R7

endmodule

// File: rtl/sync_vcount.sv
module sync_vcount
    import sync_gen_pkg::*;
#(
    parameter int FIELD_HALVES  = 525,
    parameter int VSYNC_HALVES  = 18,
    parameter int VBLANK_HALVES = 42
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    take_v,
    input  logic    half_begin,
    output vphase_t vph_nxt,
    output logic    field_begin,
    output logic    field_nxt
);

    localparam int HW = $clog2(FIELD_HALVES);
    localparam logic [HW-1:0] L_LAST  = HW'(FIELD_HALVES - 1);
    localparam logic [HW-1:0] L_BLANK = HW'(VSYNC_HALVES);
    localparam logic [HW-1:0] L_ACT   = HW'(VBLANK_HALVES);

    logic [HW-1:0] hl;
    logic [HW-1:0] hl_nxt;
    logic          field;
    vphase_t       vph;

    // half-line counter and field parity
    always_comb begin
        field_begin = take_v || (half_begin && hl == L_LAST);
        if (take_v) begin
            hl_nxt    = '0;
            field_nxt = 1'b1;
        end else if (half_begin) begin
            if (hl == L_LAST) begin
                hl_nxt    = '0;
                field_nxt = ~field;
            end else begin
                hl_nxt    = hl + 1'b1;
                field_nxt = field;
            end
        end else begin
            hl_nxt    = hl;
            field_nxt = field;
        end
    end

    // vertical phase transitions
    always_comb begin
        vph_nxt = vph;
        if (field_begin) begin
            vph_nxt = V_SYNC;
        end else if (half_begin) begin
            unique case (vph)
                V_SYNC:   if (hl_nxt == L_BLANK) vph_nxt = V_BLANK;
                V_BLANK:  if (hl_nxt == L_ACT)   vph_nxt = V_ACTIVE;
                V_ACTIVE: vph_nxt = V_ACTIVE;
            endcase
        end
    end

    // state register: reset parks at the last half-line of an odd field
    always_ff @(posedge clk) begin
        if (rst) begin
            hl    <= L_LAST;
            field <= 1'b1;
            vph   <= V_ACTIVE;
        end else begin
            hl    <= hl_nxt;
            field <= field_nxt;
            vph   <= vph_nxt;
        end
    end

    AST_GLOCK_V: assert property (@(posedge clk) disable iff (rst)
        take_v |=> (hl == '0 && field && vph == V_SYNC)); // R8
    AST_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!take_v && half_begin && hl == L_LAST) |=> (field != $past(field))); // R5
    AST_HL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!take_v && !half_begin) |=> ($stable(hl) && $stable(field))); // R5

endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
    import sync_gen_pkg::*;
#(
    parameter int LINE_CLKS     = 260,
    parameter int HSYNC_W       = 20,
    parameter int BURST_START   = 24,
    parameter int BURST_W       = 10,
    parameter int HBLANK_W      = 45,
    parameter int FIELD_HALVES  = 525,
    parameter int VSYNC_HALVES  = 18,
    parameter int VBLANK_HALVES = 42
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_en,
    input  logic ref_hsync,
    input  logic ref_vsync,
    output logic hdrive,
    output logic vdrive,
    output logic blank,
    output logic csync,
    output logic burst,
    output logic line_start,
    output logic field_start,
    output logic field_odd
);

    logic    take_h;
    logic    take_v;
    hphase_t hph_nxt;
    vphase_t vph_nxt;
    logic    line_begin;
    logic    half_begin;
    logic    field_begin;
    logic    field_nxt;
    logic    in_hs;
    logic    in_vs;

    assign take_h = lock_en & ref_hsync;
    assign take_v = lock_en & ref_vsync;

    sync_hcount #(
        .LINE_CLKS  (LINE_CLKS),
        .HSYNC_W    (HSYNC_W),
        .BURST_START(BURST_START),
        .BURST_W    (BURST_W),
        .HBLANK_W   (HBLANK_W)
    ) hcount_i (
        .clk       (clk),
        .rst       (rst),
        .take_h    (take_h),
        .hph_nxt   (hph_nxt),
        .line_begin(line_begin),
        .half_begin(half_begin)
    );

    sync_vcount #(
        .FIELD_HALVES (FIELD_HALVES),
        .VSYNC_HALVES (VSYNC_HALVES),
        .VBLANK_HALVES(VBLANK_HALVES)
    ) vcount_i (
        .clk        (clk),
        .rst        (rst),
        .take_v     (take_v),
        .half_begin (half_begin),
        .vph_nxt    (vph_nxt),
        .field_begin(field_begin),
        .field_nxt  (field_nxt)
    );

    assign in_hs = (hph_nxt == H_SYNC);
    assign in_vs = (vph_nxt == V_SYNC);

    // output register: decoded from the next phases so outputs align with the counters
    always_ff @(posedge clk) begin
        if (rst) begin
            hdrive      <= 1'b0;
            vdrive      <= 1'b0;
            blank       <= 1'b0;
            csync       <= 1'b0;
            burst       <= 1'b0;
            line_start  <= 1'b0;
            field_start <= 1'b0;
            field_odd   <= 1'b0;
        end else begin
            hdrive      <= in_hs;
            vdrive      <= in_vs;
            blank       <= (hph_nxt != H_ACTIVE) || (vph_nxt != V_ACTIVE);
            csync       <= in_hs ^ in_vs;
            burst       <= (hph_nxt == H_BURST) && !in_vs;
            line_start  <= line_begin;
            field_start <= field_begin;
            field_odd   <= field_nxt;
        end
    end

    AST_BURST_QUIET: assert property (@(posedge clk) disable iff (rst)
        burst |-> !vdrive); // R4
    AST_HD_BLANKED: assert property (@(posedge clk) disable iff (rst)
        hdrive |-> blank); // R3
    AST_LS_HD: assert property (@(posedge clk) disable iff (rst)
        line_start |-> hdrive); // R2
    AST_FS_VD: assert property (@(posedge clk) disable iff (rst)
        field_start |-> vdrive); // R11
    AST_GL_LINE: assert property (@(posedge clk) disable iff (rst)
        take_h |=> (line_start && hdrive)); // R7
    AST_GL_FIELD: assert property (@(posedge clk) disable iff (rst)
        take_v |=> (field_start && vdrive && field_odd)); // R8
    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (field_start && !take_v) |=> !field_start); // R11

endmodule

// File: tb/video_sync_gen_tb_top.sv
module video_sync_gen_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_en = 1'b0;
    logic ref_hsync = 1'b0;
    logic ref_vsync = 1'b0;
    logic hdrive, vdrive, blank, csync, burst, line_start, field_start, field_odd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    video_sync_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .lock_en    (lock_en),
        .ref_hsync  (ref_hsync),
        .ref_vsync  (ref_vsync),
        .hdrive     (hdrive),
        .vdrive     (vdrive),
        .blank      (blank),
        .csync      (csync),
        .burst      (burst),
        .line_start (line_start),
        .field_start(field_start),
        .field_odd  (field_odd)
    );

    // behavioural reference: pixel, half-line, parity and strobes
    int mp = 259;
    int mhl = 524;
    int mf = 1;
    bit m_run = 1'b0;
    bit m_ls = 1'b0;
    bit m_fs = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            mp = 259; mhl = 524; mf = 1; m_run = 1'b0; m_ls = 1'b0; m_fs = 1'b0;
        end else begin
            bit tkh, tkv, adv;
            int np;
            tkh = lock_en && ref_hsync;
            tkv = lock_en && ref_vsync;
            np = (tkh || mp == 259) ? 0 : mp + 1;
            adv = (np == 0) || (np == 130);
            m_fs = tkv || (adv && mhl == 524);
            if (tkv) begin
                mhl = 0; mf = 1;
            end else if (adv) begin
                if (mhl == 524) begin mhl = 0; mf = 1 - mf; end
                else mhl = mhl + 1;
            end
            mp = np;
            m_ls = (np == 0);
            m_run = 1'b1;
        end
    end

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b (pixel %0d half-line %0d)", req, what, got, exp, mp, mhl);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            bit ehd, evd;
            ehd = m_run && (mp < 20);
            evd = m_run && (mhl < 18);
            chk(hdrive, ehd, "R2", "hdrive");
            chk(vdrive, evd, "R5", "vdrive");
            chk(blank, m_run && (mp < 45 || mhl < 42), "R3", "blank");
            chk(burst, m_run && mp >= 24 && mp < 34 && !evd, "R4", "burst");
            chk(csync, ehd ^ evd, "R6", "csync");
            chk(line_start, m_run && m_ls, "R1", "line_start");
            chk(field_start, m_run && m_fs, "R11", "field_start");
            chk(field_odd, m_run && (mf == 1), "R5", "field_odd");
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet during reset
        chk(hdrive | vdrive | blank | csync | burst | line_start | field_start | field_odd,
            1'b0, "R10", "outputs in reset");
        rst = 1'b0;
        @(negedge clk);
        // R10: first position after reset
        chk(line_start & field_start & hdrive & vdrive, 1'b1, "R10", "start after reset");
        chk(field_odd, 1'b0, "R10", "parity after reset");

        // free run over two fields plus a margin (R1, R5)
        repeat (137000) @(negedge clk);

        // R7: horizontal genlock mid-line
        lock_en = 1'b1;
        repeat (77) @(negedge clk);
        ref_hsync = 1'b1;
        @(negedge clk);
        ref_hsync = 1'b0;
        chk(line_start & hdrive, 1'b1, "R7", "genlock horizontal");
        repeat (600) @(negedge clk);

        // R8: vertical genlock
        ref_vsync = 1'b1;
        @(negedge clk);
        ref_vsync = 1'b0;
        chk(field_start & vdrive & field_odd, 1'b1, "R8", "genlock vertical");
        repeat (15000) @(negedge clk);

        // R7 and R8 together
        ref_hsync = 1'b1;
        ref_vsync = 1'b1;
        @(negedge clk);
        ref_hsync = 1'b0;
        ref_vsync = 1'b0;
        chk(line_start & field_start, 1'b1, "R8", "combined genlock");
        repeat (100) @(negedge clk);

        // R9: pulses ignored when locking is disabled
        lock_en = 1'b0;
        ref_hsync = 1'b1;
        ref_vsync = 1'b1;
        @(negedge clk);
        ref_hsync = 1'b0;
        ref_vsync = 1'b0;
        chk(line_start | field_start, 1'b0, "R9", "pulses with lock off");
        repeat (6000) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule